// File: doc/BRIEF.md
# Interrupt Acknowledge Latency Gate

This block sits between a processor's interrupt-enable state and the logic that accepts an interrupt. It tracks whether interrupts are enabled from one-cycle enable and disable pulses issued by instruction execution. It counts how long they have stayed enabled. It lets a pending, unmasked request through only once a fixed re-arm window has run without interruption. The window restarts on every enable pulse. It also restarts when a request newly becomes valid while interrupts are enabled. A disable pulse inside the window throws the count away.

Sampling of the request is suppressed in some cycles: while the core is in a low-power idle or stop state, while an instruction that alters the interrupt-disable bit executes, and while an interrupt control register is accessed. On acceptance the block pulses an acknowledge and a pending-clear output together. A fixed number of clocks later it pulses a service-start output. It accepts nothing new until that pulse has fired.

Top module: `irq_ack_gate`

## Requirements
- R1: While reset is high and in the cycle after reset, all outputs are 0. After reset, interrupts count as disabled, so a valid request is never acknowledged until an enable pulse and a full window have passed.
- R2: With a request already valid (pending=1, masked=0), an enable pulse in cycle E gives an acknowledge in cycle E+8. That is the default window of 7 clocks plus one.
- R3: A disable pulse in any of cycles E+1..E+7 cancels the acknowledgment. So does a disable pulse in the same cycle as the enable pulse, because disable wins. No acknowledge follows until a new enable.
- R4: A disable pulse in cycle E+8 does not stop the acknowledge in that same cycle.
- R5: While enabled, a request that becomes valid in cycle R restarts the window and is acknowledged in cycle R+8, even if the earlier window had already run out.
- R6: A request counts only when pending=1 and masked=0. Clearing the mask of a pending request counts as the request becoming valid (R5 timing).
- R7: No acknowledge occurs in a cycle with the low-power indicator at 1. When it drops after the window has elapsed, the acknowledge comes in that same cycle.
- R8: No acknowledge occurs in a cycle whose disable-bit-instruction strobe is 1.
- R9: No acknowledge occurs in a cycle whose control-register-access strobe is 1.
- R10: The pending-clear output pulses in exactly the cycles where the acknowledge output pulses.
- R11: Service-start is a one-cycle pulse 4 cycles after each acknowledge (acknowledge in A, service-start in A+4).
- R12: No acknowledge occurs in cycles A+1..A+4. With a request held valid and the window elapsed, the next acknowledge comes in A+5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en_pulse | input | 1 | One-cycle pulse: interrupts enabled |
| irq_dis_pulse | input | 1 | One-cycle pulse: interrupts disabled |
| req_pending | input | 1 | Request pending flag |
| req_masked | input | 1 | Request mask flag (1 = masked) |
| low_power | input | 1 | Core is in an idle or stop state |
| idbit_instr | input | 1 | An instruction altering the interrupt-disable bit executes this cycle |
| ictl_access | input | 1 | An interrupt control register is accessed this cycle |
| ack_o | output | 1 | Request acknowledged this cycle |
| pend_clr_o | output | 1 | Clear strobe for the pending flag |
| svc_start_o | output | 1 | Service routine starts this cycle |

## Verification
The bench builds the gate with its defaults: a 7-clock window, a 4-clock service delay and the variant that restarts the window on a new request. These small values keep every edge of the window within a few cycles. That covers disables just inside and just outside it, a request arriving after the window has elapsed, and back-to-back acceptances spaced by the service delay. A behavioural model predicts all three outputs on every clock.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

   // Conditions that stop the request from being sampled in a cycle
   typedef struct packed {
      logic low_power;
      logic idbit_instr;
      logic ictl_access;
   } sample_block_t;

   function automatic logic sampling_blocked(input sample_block_t b);
      return b.low_power | b.idbit_instr | b.ictl_access;
   endfunction

endpackage

// File: rtl/irq_window_timer.sv
module irq_window_timer #(
   parameter int WINDOW_CLKS    = 7,
   parameter bit RESTART_ON_REQ = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic en_pulse_i,
   input  logic dis_pulse_i,
   input  logic req_valid_i,
   output logic enabled_o,
   output logic elapsed_o,
   output logic fresh_req_o
);

   localparam int CNT_W = $clog2(WINDOW_CLKS + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WINDOW_CLKS);

   logic             en_q;
   logic [CNT_W-1:0] cnt_q;
   logic             fresh;

   generate
      if (RESTART_ON_REQ) begin : g_restart
         logic req_q;
         always_ff @(posedge clk) begin
            if (rst) req_q <= 1'b0;
            else     req_q <= req_valid_i;
         end
         assign fresh = en_q & req_valid_i & ~req_q;
      end else begin : g_no_restart
         logic unused_req;
         assign unused_req = req_valid_i;
         assign fresh      = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q  <= 1'b0;
         cnt_q <= '0;
      end else if (dis_pulse_i) begin
         en_q  <= 1'b0;
         cnt_q <= '0;
      end else if (en_pulse_i) begin
         en_q  <= 1'b1;
         cnt_q <= '0;
      end else if (fresh) begin
         cnt_q <= '0;
      end else if (en_q && cnt_q != CNT_FULL) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign enabled_o   = en_q;
   assign elapsed_o   = en_q && (cnt_q == CNT_FULL);
   assign fresh_req_o = fresh;

endmodule

// File: rtl/irq_service_delay.sv
module irq_service_delay #(
   parameter int DELAY_CLKS = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   output logic busy_o,
   output logic fire_o
);

   localparam int DLY_W = $clog2(DELAY_CLKS + 1);
   localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(DELAY_CLKS);

   logic [DLY_W-1:0] dly_q;

   always_ff @(posedge clk) begin
      if (rst)               dly_q <= '0;
      else if (start_i)      dly_q <= DLY_LOAD;
      else if (dly_q != '0)  dly_q <= dly_q - DLY_W'(1);
   end

   assign busy_o = (dly_q != '0);
   assign fire_o = (dly_q == DLY_W'(1));

endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
   import irq_gate_pkg::*;
(
   input  logic          elapsed_i,
   input  logic          fresh_req_i,
   input  logic          req_valid_i,
   input  logic          busy_i,
   input  sample_block_t block_i,
   output logic          accept_o
);

   always_comb begin
      accept_o = elapsed_i & req_valid_i & ~fresh_req_i & ~busy_i;
      if (sampling_blocked(block_i)) accept_o = 1'b0;
   end

endmodule

// File: rtl/irq_ack_gate.sv
module irq_ack_gate
   import irq_gate_pkg::*;
#(
   parameter int WINDOW_CLKS    = 7,
   parameter int SERVICE_DELAY  = 4,
   parameter bit RESTART_ON_REQ = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic irq_en_pulse,
   input  logic irq_dis_pulse,
   input  logic req_pending,
   input  logic req_masked,
   input  logic low_power,
   input  logic idbit_instr,
   input  logic ictl_access,
   output logic ack_o,
   output logic pend_clr_o,
   output logic svc_start_o
);

   generate
      if (WINDOW_CLKS < 1) begin : g_bad_window
         $error("WINDOW_CLKS must be at least 1");
      end
      if (SERVICE_DELAY < 1) begin : g_bad_delay
         $error("SERVICE_DELAY must be at least 1");
      end
   endgenerate

   logic          req_valid;
   logic          win_enabled;
   logic          win_elapsed;
   logic          win_fresh;
   logic          dly_busy;
   logic          dly_fire;
   logic          accept;
   sample_block_t blk;

   assign req_valid       = req_pending & ~req_masked;
   assign blk.low_power   = low_power;
   assign blk.idbit_instr = idbit_instr;
   assign blk.ictl_access = ictl_access;

   irq_window_timer #(
      .WINDOW_CLKS   (WINDOW_CLKS),
      .RESTART_ON_REQ(RESTART_ON_REQ)
   ) i_timer (
      .clk        (clk),
      .rst        (rst),
      .en_pulse_i (irq_en_pulse),
      .dis_pulse_i(irq_dis_pulse),
      .req_valid_i(req_valid),
      .enabled_o  (win_enabled),
      .elapsed_o  (win_elapsed),
      .fresh_req_o(win_fresh)
   );

   irq_accept_gate i_gate (
      .elapsed_i  (win_elapsed),
      .fresh_req_i(win_fresh),
      .req_valid_i(req_valid),
      .busy_i     (dly_busy),
      .block_i    (blk),
      .accept_o   (accept)
   );

   irq_service_delay #(
      .DELAY_CLKS(SERVICE_DELAY)
   ) i_delay (
      .clk    (clk),
      .rst    (rst),
      .start_i(accept),
      .busy_o (dly_busy),
      .fire_o (dly_fire)
   );

   logic unused_en;
   assign unused_en   = win_enabled;

   assign ack_o       = accept;
   assign pend_clr_o  = accept;
   assign svc_start_o = dly_fire;

endmodule

// File: rtl/irq_ack_gate_chk.sv
module irq_ack_gate_chk #(
   parameter int SERVICE_DELAY = 4
) (
   input logic clk,
   input logic rst,
   input logic irq_dis_pulse,
   input logic req_pending,
   input logic req_masked,
   input logic low_power,
   input logic idbit_instr,
   input logic ictl_access,
   input logic ack_o,
   input logic svc_start_o
);

   localparam int SA_W = $clog2(SERVICE_DELAY + 2);
   localparam logic [SA_W-1:0] SA_TOP = SA_W'(SERVICE_DELAY + 1);

   // cycles since the last acknowledge, saturating just past the delay
   logic [SA_W-1:0] since_ack;
   always_ff @(posedge clk) begin
      if (rst)                      since_ack <= '0;
      else if (ack_o)               since_ack <= SA_W'(1);
      else if (since_ack != '0 && since_ack != SA_TOP)
                                    since_ack <= since_ack + SA_W'(1);
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!ack_o && !svc_start_o));

   // R3
   dis_blocks_next_chk: assert property (@(posedge clk) disable iff (rst)
      irq_dis_pulse |=> !ack_o);

   // R6
   ack_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
      ack_o |-> (req_pending && !req_masked));

   // R7
   lowpwr_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
      low_power |-> !ack_o);

   // R8
   idbit_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
      idbit_instr |-> !ack_o);

   // R9
   ictl_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
      ictl_access |-> !ack_o);

   // R11
   svc_delay_chk: assert property (@(posedge clk) disable iff (rst)
      svc_start_o |-> (since_ack == SA_W'(SERVICE_DELAY)));

   // R12
   busy_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
      (since_ack != '0 && since_ack != SA_TOP) |-> !ack_o);

endmodule

bind irq_ack_gate irq_ack_gate_chk #(.SERVICE_DELAY(SERVICE_DELAY)) i_chk (
   .clk          (clk),
   .rst          (rst),
   .irq_dis_pulse(irq_dis_pulse),
   .req_pending  (req_pending),
   .req_masked   (req_masked),
   .low_power    (low_power),
   .idbit_instr  (idbit_instr),
   .ictl_access  (ictl_access),
   .ack_o        (ack_o),
   .svc_start_o  (svc_start_o)
);

// File: tb/test_irq_ack_gate.sv
`timescale 1ns/100ps
module test_irq_ack_gate;

   localparam int WIN = 7;
   localparam int SVC = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en_p = 0, dis_p = 0, pend = 0, mask = 0, lp = 0, idb = 0, ctl = 0;
   logic ack, clr, svc;

   irq_ack_gate i_irq_ack_gate (
      .clk(clk), .rst(rst), .irq_en_pulse(en_p), .irq_dis_pulse(dis_p),
      .req_pending(pend), .req_masked(mask), .low_power(lp),
      .idbit_instr(idb), .ictl_access(ctl),
      .ack_o(ack), .pend_clr_o(clr), .svc_start_o(svc)
   );

   always #2.5 clk = ~clk;

   int checks = 0, fails = 0;
   int cyc_n = 0, ack_cnt = 0, clr_cnt = 0, last_ack = -1, last_svc = -1;
   string cur_tag = "R1";

   // behavioural reference state
   int m_en = 0, m_age = 0, m_vprev = 0, m_wait = 0;

   function automatic int m_valid();
      return (pend === 1'b1 && mask === 1'b0) ? 1 : 0;
   endfunction
   function automatic int m_fresh();
      return (m_en != 0 && m_valid() != 0 && m_vprev == 0) ? 1 : 0;
   endfunction
   function automatic int m_ack();
      if (m_en == 0 || m_age < WIN || m_valid() == 0) return 0;
      if (m_fresh() != 0 || m_wait != 0) return 0;
      if (lp || idb || ctl) return 0;
      return 1;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc_n);
      end
   endtask

   always @(posedge clk) begin
      cyc_n <= cyc_n + 1;
      if (rst) begin
         m_en = 0; m_age = 0; m_vprev = 0; m_wait = 0;
      end else begin
         int a;
         int f;
         a = m_ack();
         f = m_fresh();
         if (dis_p)            begin m_en = 0; m_age = 0; end
         else if (en_p)        begin m_en = 1; m_age = 0; end
         else if (f != 0)      m_age = 0;
         else if (m_en != 0 && m_age < WIN) m_age = m_age + 1;
         if (a != 0)           m_wait = SVC;
         else if (m_wait > 0)  m_wait = m_wait - 1;
         m_vprev = m_valid();
      end
   end

   always @(negedge clk) begin
      if (cyc_n >= 1) begin
         int ea;
         ea = rst ? 0 : m_ack();
         check(ack === 1'(ea), {cur_tag, " ack"}, int'(ack), ea);
         check(clr === ack, "R10 pend_clr", int'(clr), int'(ack));
         check(svc === 1'((!rst && m_wait == 1) ? 1 : 0), "R11 svc_start",
               int'(svc), (!rst && m_wait == 1) ? 1 : 0);
         if (ack === 1'b1) begin ack_cnt++; last_ack = cyc_n; end
         if (clr === 1'b1) clr_cnt++;
         if (svc === 1'b1) last_svc = cyc_n;
      end
   end

   always @(posedge clk) begin
      if (cyc_n > 20000) begin
         checks++; fails++;
         $display("FAIL watchdog (all R) actual=%0d expected<%0d", cyc_n, 20000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic step(input int n = 1);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   initial begin
      int e;
      int mark;
      // R1: reset with a valid request present
      pend = 1;
      step(3);
      check(ack === 0 && svc === 0 && clr === 0, "R1 outputs in reset", int'(ack), 0);
      rst = 0;
      step(12);
      check(ack_cnt == 0, "R1 no ack before enable", ack_cnt, 0);

      // R2: request already valid, then enable
      cur_tag = "R2";
      en_p = 1; e = cyc_n; step; en_p = 0;
      step(8);
      check(last_ack == e + 8, "R2 ack cycle", last_ack, e + 8);
      check(ack_cnt == 1, "R2 ack count", ack_cnt, 1);
      pend = 0;
      step(4);
      check(last_svc == last_ack + 4, "R11 svc after ack", last_svc, last_ack + 4);

      // R3: disable inside the window, and enable+disable together
      cur_tag = "R3";
      mark = ack_cnt;
      pend = 1; step(3);
      dis_p = 1; step; dis_p = 0;
      step(12);
      check(ack_cnt == mark, "R3 disable in window", ack_cnt, mark);
      en_p = 1; dis_p = 1; step; en_p = 0; dis_p = 0;
      step(12);
      check(ack_cnt == mark, "R3 disable wins over enable", ack_cnt, mark);

      // R4: disable on the eighth clock
      cur_tag = "R4";
      en_p = 1; e = cyc_n; step; en_p = 0;
      step(7);
      dis_p = 1; step; dis_p = 0; pend = 0;
      check(last_ack == e + 8, "R4 ack despite late disable", last_ack, e + 8);
      step(5);

      // R5: request arrives after the window elapsed
      cur_tag = "R5";
      en_p = 1; step; en_p = 0;
      step(12);
      pend = 1; e = cyc_n;
      step(9);
      check(last_ack == e + 8, "R5 request restarts window", last_ack, e + 8);
      pend = 0; step(5);

      // R6: masked request, then unmask
      cur_tag = "R6";
      mark = ack_cnt;
      mask = 1; pend = 1; step(15);
      check(ack_cnt == mark, "R6 masked no ack", ack_cnt, mark);
      mask = 0; e = cyc_n;
      step(9);
      check(last_ack == e + 8, "R6 unmask restarts window", last_ack, e + 8);
      pend = 0; step(5);

      // R7: low-power hold-off
      cur_tag = "R7";
      mark = ack_cnt;
      lp = 1; pend = 1; step(15);
      check(ack_cnt == mark, "R7 low power no ack", ack_cnt, mark);
      lp = 0; e = cyc_n; step;
      check(last_ack == e, "R7 ack when low power drops", last_ack, e);
      pend = 0; step(5);

      // R8: disable-bit instruction strobe
      cur_tag = "R8";
      mark = ack_cnt;
      idb = 1; pend = 1; step(12);
      check(ack_cnt == mark, "R8 idbit strobe no ack", ack_cnt, mark);
      idb = 0; e = cyc_n; step;
      check(last_ack == e, "R8 ack after strobe", last_ack, e);
      pend = 0; step(5);

      // R9: control-register access strobe
      cur_tag = "R9";
      mark = ack_cnt;
      ctl = 1; pend = 1; step(12);
      check(ack_cnt == mark, "R9 ctl access no ack", ack_cnt, mark);
      ctl = 0; e = cyc_n; step;
      check(last_ack == e, "R9 ack after access", last_ack, e);
      pend = 0; step(5);

      // R12: held request, back-to-back acceptances
      cur_tag = "R12";
      mark = ack_cnt;
      pend = 1; e = cyc_n;
      step(14);
      check(ack_cnt == mark + 2, "R12 two acks", ack_cnt, mark + 2);
      check(last_ack == e + 13, "R12 second ack spacing", last_ack, e + 13);
      pend = 0; step(6);

      check(clr_cnt == ack_cnt, "R10 clear count", clr_cnt, ack_cnt);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule